// File: doc/BRIEF.md
# High-Priority Queue Starvation Escalator

This block watches one high-priority request queue of a memory controller and decides when that queue has waited long enough to be forced ahead of other traffic. A free-running prescaler divides the clock into ticks of 32 cycles. While the queue holds work and the scheduler grants it nothing, a starvation timer counts ticks. When the timer reaches its limit, the block raises a critical flag. It also loads a run counter with the number of transactions the queue may push through before it gives up its priority.

While critical, every grant spends one unit of the run counter. The flag drops when the counter is spent or when the queue runs dry. A holdoff timer then keeps the queue non-critical for a guaranteed number of ticks before starvation counting may resume. All three settings arrive packed in one control word. They are captured only when the flag rises or falls, so a change written mid-episode never disturbs the episode in progress. The block has no data stream: every pin is a plain control or status level.

Top module: `hpq_escalator`

## Requirements
- R1: A tick occurs on every 32nd clock edge after reset release, the first on the 32nd edge. Both timers advance only on tick edges, and `critical` can rise only on a tick edge.
- R2: While non-critical and out of holdoff, with starvation limit L in force, `critical` rises on the (L+1)-th tick edge at which `pend_cnt` is non-zero and `grant` is low. Tick edges with `pend_cnt` equal to zero are not counted, and the count is kept.
- R3: A `grant` while non-critical clears the starvation count, so L+1 further starved ticks are needed after it.
- R4: On the edge where `critical` rises, `run_left` loads the smaller of the run-length field `ctl_word[25:22]` (read live on that edge) and `pend_cnt`.
- R5: While critical, each `grant` with `run_left` non-zero lowers `run_left` by one. `critical` and `run_left` both read zero after the edge at which the count is spent. A loaded count of zero ends the episode after one cycle.
- R6: While critical, an edge that samples `pend_cnt` equal to zero clears `critical` and `run_left`, whatever count remains.
- R7: After `critical` falls, with holdoff setting H (`ctl_word[10:0]`), starvation counting is suspended for H+1 tick edges. If the queue stays starved throughout, `critical` rises again on exactly the (H+L+2)-th tick edge after the fall.
- R8: A starvation or holdoff setting of zero is met on the next tick edge and never on the edge of the transition itself.
- R9: The starvation limit (`ctl_word[21:11]`) and the holdoff in force are those captured from `ctl_word` on the latest rise or fall of `critical`. Writes between transitions have no effect until the next one. After reset, all three captured fields are 15.
- R10: During and right after reset, `critical` is 0 and `run_left` is 0. `run_left` is 0 whenever `critical` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 26 | Settings: run length [25:22], starvation limit in ticks [21:11], holdoff in ticks [10:0] |
| pend_cnt | input | 6 | Number of transactions waiting in the queue |
| grant | input | 1 | One-cycle pulse per transaction served from the queue |
| critical | output | 1 | Queue is escalated to critical priority |
| run_left | output | 4 | Transactions still allowed in the current critical episode |

## Verification
The bench builds the block with its default parameters: a 5-bit prescaler, 11-bit timers, a 4-bit run length and a 6-bit pending count. With these values, pending counts both above and below the run-length field can be applied, which covers both outcomes of the minimum on entry. Zero limits and holdoffs reach escalation within two ticks, so many episodes fit into a short run. The reset limit of 15 is still exercised once, from the start.

// File: rtl/hpq_pkg.sv
package hpq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CRIT = 2'd1,
    ST_HOLD = 2'd2
  } esc_state_t;

  localparam int unsigned SETTING_RESET = 15;

endpackage

// File: rtl/hpq_tick_gen.sv
module hpq_tick_gen #(
  parameter int unsigned PRE_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam logic [PRE_W-1:0] LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/hpq_tick_timer.sv
module hpq_tick_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  assign hit = adv && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (adv && !hit) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hpq_run_counter.sv
module hpq_run_counter #(
  parameter int unsigned RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RUN_W-1:0] load_val,
  input  logic             clear,
  input  logic             dec,
  output logic [RUN_W-1:0] cnt,
  output logic             spent
);
  logic             step;
  logic [RUN_W-1:0] cnt_nx;

  assign step   = dec && (cnt != '0);
  assign cnt_nx = cnt - RUN_W'(step);
  assign spent  = (cnt_nx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (load)  cnt <= load_val;
    else            cnt <= cnt_nx;
  end
endmodule

// File: rtl/hpq_escalator.sv
module hpq_escalator
  import hpq_pkg::*;
#(
  parameter int unsigned PRE_W  = 5,
  parameter int unsigned LIM_W  = 11,
  parameter int unsigned RUN_W  = 4,
  parameter int unsigned PEND_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [RUN_W+2*LIM_W-1:0]    ctl_word,
  input  logic [PEND_W-1:0]           pend_cnt,
  input  logic                        grant,
  output logic                        critical,
  output logic [RUN_W-1:0]            run_left
);
  localparam int unsigned CTL_W   = RUN_W + 2 * LIM_W;
  localparam int unsigned HOLD_LO = 0;
  localparam int unsigned STV_LO  = LIM_W;
  localparam int unsigned RUN_LO  = 2 * LIM_W;
  localparam int unsigned CMP_W   = (PEND_W > RUN_W) ? PEND_W : RUN_W;
  localparam logic [CTL_W-1:0] CTL_RST = {RUN_W'(SETTING_RESET),
                                          LIM_W'(SETTING_RESET),
                                          LIM_W'(SETTING_RESET)};

  esc_state_t       state_q, state_d;
  logic [CTL_W-1:0] held_q;
  logic             tick;
  logic             starve_hit, hold_hit;
  logic             run_spent;
  logic             enter_crit, leave_crit;
  logic             pend_any;
  logic [RUN_W-1:0] run_live, run_load;
  logic [CMP_W-1:0] pend_x, run_x;

  hpq_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  assign pend_any = (pend_cnt != '0);

  hpq_tick_timer #(.CNT_W(LIM_W)) u_starve (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  ((state_q != ST_IDLE) || grant),
    .adv  (tick && (state_q == ST_IDLE) && pend_any && !grant),
    .limit(held_q[STV_LO +: LIM_W]),
    .hit  (starve_hit)
  );

  hpq_tick_timer #(.CNT_W(LIM_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state_q != ST_HOLD),
    .adv  (tick && (state_q == ST_HOLD)),
    .limit(held_q[HOLD_LO +: LIM_W]),
    .hit  (hold_hit)
  );

  assign run_live = ctl_word[RUN_LO +: RUN_W];
  assign pend_x   = CMP_W'(pend_cnt);
  assign run_x    = CMP_W'(run_live);
  assign run_load = (pend_x < run_x) ? RUN_W'(pend_x) : run_live;

  assign enter_crit = (state_q == ST_IDLE) && starve_hit;
  assign leave_crit = (state_q == ST_CRIT) && (run_spent || !pend_any);

  hpq_run_counter #(.RUN_W(RUN_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (enter_crit),
    .load_val(run_load),
    .clear   (leave_crit || (state_q != ST_CRIT && !enter_crit)),
    .dec     (grant && (state_q == ST_CRIT)),
    .cnt     (run_left),
    .spent   (run_spent)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (enter_crit) state_d = ST_CRIT;
      ST_CRIT: if (leave_crit) state_d = ST_HOLD;
      ST_HOLD: if (hold_hit)   state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      held_q  <= CTL_RST;
    end else begin
      state_q <= state_d;
      if (enter_crit || leave_crit) held_q <= ctl_word;
    end
  end

  assign critical = (state_q == ST_CRIT);
endmodule

// File: rtl/hpq_escalator_chk.sv
module hpq_escalator_chk #(
  parameter int unsigned LIM_W  = 11,
  parameter int unsigned RUN_W  = 4,
  parameter int unsigned PEND_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [RUN_W+2*LIM_W-1:0] ctl_word,
  input logic [PEND_W-1:0]        pend_cnt,
  input logic                     grant,
  input logic                     critical,
  input logic [RUN_W-1:0]         run_left,
  input logic                     tick
);
  localparam int unsigned RUN_LO = 2 * LIM_W;

  a_r1_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(critical) |-> $past(tick));

  a_r4_load_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(critical) |-> ({{(32-RUN_W){1'b0}}, run_left} <= {{(32-PEND_W){1'b0}}, $past(pend_cnt)})
                     && (run_left <= $past(ctl_word[RUN_LO +: RUN_W])));

  a_r5_grant_spends: assert property (@(posedge clk) disable iff (!rst_n)
    (critical && grant && run_left != '0 && pend_cnt != '0) |=> (run_left == $past(run_left) - 1'b1));

  a_r5_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (critical && !grant && pend_cnt != '0 && run_left != '0) |=> (critical && $stable(run_left)));

  a_r6_empty_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (critical && pend_cnt == '0) |=> !critical);

  a_r7_no_bounce: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(critical) |=> !critical);

  a_r10_idle_run_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !critical |-> (run_left == '0));
endmodule

bind hpq_escalator hpq_escalator_chk #(
  .LIM_W (LIM_W),
  .RUN_W (RUN_W),
  .PEND_W(PEND_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctl_word(ctl_word),
  .pend_cnt(pend_cnt),
  .grant   (grant),
  .critical(critical),
  .run_left(run_left),
  .tick    (tick)
);

// File: tb/sim_hpq_escalator.sv
module sim_hpq_escalator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] ctl_word = {4'd15, 11'd15, 11'd15};
  logic [5:0]  pend_cnt = '0;
  logic        grant = 1'b0;
  logic        critical;
  logic [3:0]  run_left;

  int n_chk = 0;
  int n_bad = 0;
  int k = 0;
  bit done = 0;

  // columns: run, lim, hold, pend, drop, scramble, exp_cycles, exp_ticks, exp_load
  localparam int NV = 6;
  localparam int VEC [NV][9] = '{
    '{ 3, 2, 1,  7, 0, 0, 9, 5, 3},
    '{15, 0, 0,  4, 1, 0, 1, 2, 4},
    '{ 6, 3, 2, 20, 0, 1, 4, 7, 6},
    '{ 0, 1, 0,  5, 0, 0, 6, 3, 0},
    '{ 2, 4, 3,  1, 0, 0, 1, 9, 1},
    '{ 8, 5, 1, 12, 1, 0, 1, 8, 8}
  };

  hpq_escalator u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_word(ctl_word),
    .pend_cnt(pend_cnt),
    .grant   (grant),
    .critical(critical),
    .run_left(run_left)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) k <= k + 1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic set_cfg(int run, int lim, int hold);
    ctl_word = {4'(run), 11'(lim), 11'(hold)};
  endtask

  // counts tick edges until critical is seen high at a falling edge
  task automatic wait_crit(output int ticks);
    ticks = 0;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (k % 32 == 0) ticks++;
      if (critical) return;
    end
    ticks = -1;
  endtask

  // serves or empties the queue until critical drops; returns cycles spent critical
  task automatic drain(bit drop, output int cyc);
    cyc = 0;
    while (critical && cyc < 100) begin
      if (drop) pend_cnt = '0;
      else      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      cyc++;
    end
  endtask

  // waits n tick edges; returns 1 if critical was ever seen high
  task automatic wait_ticks(int n, output bit seen);
    int t = 0;
    seen = 0;
    while (t < n) begin
      @(negedge clk);
      if (k % 32 == 0) t++;
      if (critical) seen = 1;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  initial begin
    int  ticks, cyc, first;
    bit  seen;

    // R10: reset state
    #5;
    chk("R10 critical in reset", int'(critical), 0);
    chk("R10 run_left in reset", int'(run_left), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: first tick lands on edge 32; R2: empty queue does not count
    first = 0;
    while (first == 0) begin
      @(negedge clk);
      if (k % 32 == 0) first = k;
    end
    chk("R1 first tick edge", first, 32);
    wait_ticks(2, seen);
    chk("R2 empty queue never escalates", int'(seen), 0);

    // R9: reset limit 15 -> 16 starved ticks; R4: load min(15, 9)
    pend_cnt = 6'd9;
    wait_crit(ticks);
    chk("R9 reset limit ticks", ticks, 16);
    chk("R1 rise on tick edge", k % 32, 0);
    chk("R4 load from reset run", int'(run_left), 9);

    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      drain(VEC[v][4] != 0, cyc);
      chk(VEC[v][4] != 0 ? "R6 empty exit cycles" : "R5 grant exit cycles", cyc, VEC[v][6]);
      chk("R5 critical low after exit", int'(critical), 0);
      chk("R5 run_left zero after exit", int'(run_left), 0);
      pend_cnt = 6'(VEC[v][3]);
      if (VEC[v][5] != 0) set_cfg(VEC[v][0], 0, 0);  // R9: ignored until next transition
      wait_crit(ticks);
      chk(VEC[v][1] == 0 ? "R8 zero settings ticks" : "R7 holdoff plus starve ticks", ticks, VEC[v][7]);
      chk("R4 run load", int'(run_left), VEC[v][8]);
    end

    // R7/R2: holdoff then idle with empty queue
    set_cfg(8, 3, 2);
    drain(1'b0, cyc);
    chk("R5 grant exit cycles", cyc, 8);
    pend_cnt = '0;
    wait_ticks(6, seen);
    chk("R2 no escalation with empty queue", int'(seen), 0);

    // R3: grant clears the starvation count
    pend_cnt = 6'd5;
    wait_ticks(2, seen);
    chk("R3 no escalation before limit", int'(seen), 0);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    wait_crit(ticks);
    chk("R3 ticks after grant", ticks, 4);
    chk("R4 load limited by pending", int'(run_left), 5);

    // R10: reset during an episode
    rst_n = 1'b0;
    #1;
    chk("R10 critical cleared by reset", int'(critical), 0);
    chk("R10 run_left cleared by reset", int'(run_left), 0);

    wrap_up();
  end
endmodule